// File: doc/BRIEF.md
# USB Device Interrupt Status Byte

This block holds the eight-bit interrupt status byte of a USB device controller. Six of its positions are latched event flags. They are set by single-cycle pulses from the protocol engine: bus reset, the endpoint-0 control events, and an IN token to endpoint 2 that finds no armed data. The other two positions are live mirrors of buffer state: endpoint 1 holding a received packet, and endpoint 2 having a free transmit buffer. Software cannot clear the two mirrors.

Software reads the byte and clears flags by writing zero to each flag it wants to drop. A written one leaves its flag unchanged. An eight-bit enable mask selects which positions raise the registered interrupt request line. A small state machine tracks endpoint 2. It enters a NAK state when an IN token finds no armed data and stays there until the protocol engine reports that data has been armed. While in that state it drives a NAK request to the protocol engine.

Top module: `usb_irq_flags`

## Requirements
- R1: After reset `flags_o` reads 0x10 whenever `ep1_full_i`=0 and `ep2_empty_i`=1, and `irq_o` and `ep2_nak_o` are 0.
- R2: Bit positions from bit 7 down to bit 0 are: bus reset, EP1 full, EP2 transfer request, EP2 empty, setup token, EP0 OUT done, EP0 IN request, EP0 IN done.
- R3: Each event pulse sets its latched flag (bits 7, 5, 3, 2, 1, 0) one cycle later. The flag stays set until software clears it.
- R4: A write with `wr_en_i`=1 clears, one cycle later, each latched flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R5: Bits 6 and 4 always equal `ep1_full_i` and `ep2_empty_i` in the same cycle. CPU writes never change them.
- R6: If a set pulse and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R7: `irq_o` is 1 in the cycle after (flags & `irq_en_i`) is nonzero and 0 in the cycle after it becomes zero.
- R8: An EP2 IN token while the state machine is in its IDLE state moves it to NAK, which sets bit 5 and raises `ep2_nak_o` one cycle later.
- R9: `ep2_nak_o` falls one cycle after `ep2_armed_i`, whether or not bit 5 has been cleared, and the machine returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_rst_i | input | 1 | Bus reset detected pulse |
| setup_i | input | 1 | Setup token received pulse |
| ep0_out_done_i | input | 1 | EP0 OUT transfer done pulse |
| ep0_in_req_i | input | 1 | EP0 IN request pulse |
| ep0_in_done_i | input | 1 | EP0 IN transfer done pulse |
| ep2_in_tok_i | input | 1 | IN token to endpoint 2 pulse |
| ep2_data_rdy_i | input | 1 | Level: endpoint 2 has armed transmit data |
| ep2_armed_i | input | 1 | Pulse: software armed endpoint 2 data |
| ep1_full_i | input | 1 | Level: endpoint 1 holds a valid packet |
| ep2_empty_i | input | 1 | Level: an endpoint 2 buffer is free |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data (0 clears) |
| irq_en_i | input | 8 | Interrupt enable mask |
| flags_o | output | 8 | Readable status byte |
| irq_o | output | 1 | Registered interrupt request |
| ep2_nak_o | output | 1 | Request to answer NAK on EP2 |

## Verification
A flag stuck at its set or cleared value shows on `flags_o` one cycle after the pulse or write that should have changed it. A wrong mask term shows on `irq_o` one cycle after that. A state machine stuck in NAK or IDLE shows on `ep2_nak_o` one cycle after the IN token or the arming pulse. Every fault therefore appears at the ports within two cycles of its stimulus.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int FLAG_W = 8;
    localparam int B_BRST  = 7;
    localparam int B_EP1F  = 6;
    localparam int B_EP2TR = 5;
    localparam int B_EP2E  = 4;
    localparam int B_SETUP = 3;
    localparam int B_E0OTS = 2;
    localparam int B_E0ITR = 1;
    localparam int B_E0ITS = 0;
    localparam logic [FLAG_W-1:0] STATUS_MASK = (1 << B_EP1F) | (1 << B_EP2E);
    typedef enum logic [0:0] {EP2_IDLE = 1'b0, EP2_NAK = 1'b1} ep2_state_e;
endpackage

// File: rtl/usb_ep2_nak_fsm.sv
module usb_ep2_nak_fsm
    import usb_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_tok_i,
    input  logic data_rdy_i,
    input  logic armed_i,
    output logic tr_set_o,
    output logic nak_o
);
    ep2_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= EP2_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tr_set_o = 1'b0;
        unique case (state_q)
            EP2_IDLE: if (in_tok_i && !data_rdy_i && !armed_i) begin
                state_d  = EP2_NAK;
                tr_set_o = 1'b1;
            end
            EP2_NAK: if (armed_i) state_d = EP2_IDLE;
            default: state_d = EP2_IDLE;
        endcase
    end

    always_comb nak_o = (state_q == EP2_NAK);

    AST_NAK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_i |=> !nak_o); // R9
    AST_NAK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tr_set_o |=> nak_o); // R8
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank
    import usb_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    output logic [FLAG_W-1:0] latched_o
);
    logic [FLAG_W-1:0] q;

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        if (STATUS_MASK[b]) begin : g_status
            always_comb q[b] = 1'b0;
        end else begin : g_latch
            always_ff @(posedge clk_i) begin
                if (!rst_ni)       q[b] <= 1'b0;
                else if (set_i[b]) q[b] <= 1'b1;
                else if (wr_en_i && !wr_data_i[b]) q[b] <= 1'b0;
            end
        end
    end

    assign latched_o = q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(set_i & ~STATUS_MASK) |=> ((latched_o & $past(set_i) & ~STATUS_MASK) == ($past(set_i) & ~STATUS_MASK))); // R6
    AST_KEEP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && set_i == '0) |=> (latched_o == ($past(latched_o) & $past(wr_data_i) & ~STATUS_MASK))); // R4
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_rst_i,
    input  logic              setup_i,
    input  logic              ep0_out_done_i,
    input  logic              ep0_in_req_i,
    input  logic              ep0_in_done_i,
    input  logic              ep2_in_tok_i,
    input  logic              ep2_data_rdy_i,
    input  logic              ep2_armed_i,
    input  logic              ep1_full_i,
    input  logic              ep2_empty_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    input  logic [FLAG_W-1:0] irq_en_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o,
    output logic              ep2_nak_o
);
    logic              ep2_tr_set;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] latched;
    logic [FLAG_W-1:0] status;
    logic              irq_q;

    usb_ep2_nak_fsm u_ep2 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .in_tok_i   (ep2_in_tok_i),
        .data_rdy_i (ep2_data_rdy_i),
        .armed_i    (ep2_armed_i),
        .tr_set_o   (ep2_tr_set),
        .nak_o      (ep2_nak_o)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_BRST]  = bus_rst_i;
        set_vec[B_EP2TR] = ep2_tr_set;
        set_vec[B_SETUP] = setup_i;
        set_vec[B_E0OTS] = ep0_out_done_i;
        set_vec[B_E0ITR] = ep0_in_req_i;
        set_vec[B_E0ITS] = ep0_in_done_i;
        status           = '0;
        status[B_EP1F]   = ep1_full_i;
        status[B_EP2E]   = ep2_empty_i;
    end

    usb_flag_bank u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_vec),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .latched_o (latched)
    );

    assign flags_o = latched | status;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= |(flags_o & irq_en_i);
    end
    assign irq_o = irq_q;

    AST_STATUS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[B_EP1F] == ep1_full_i && flags_o[B_EP2E] == ep2_empty_i); // R5
    AST_IRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags_o & irq_en_i) == '0) |=> !irq_o); // R7
    AST_SET_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_i |=> flags_o[B_BRST]); // R3
endmodule

// File: tb/test_usb_irq_flags.sv
module test_usb_irq_flags;
    logic clk = 0, rst_n = 0;
    logic bus_rst = 0, setup = 0, e0o = 0, e0ir = 0, e0is = 0;
    logic tok = 0, rdy = 0, armed = 0, ep1f = 0, ep2e = 1, wr = 0;
    logic [7:0] wd = 8'hFF, en = 8'h00;
    logic [7:0] flags;
    logic irq, nak;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    usb_irq_flags i_usb_irq_flags (
        .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .setup_i(setup),
        .ep0_out_done_i(e0o), .ep0_in_req_i(e0ir), .ep0_in_done_i(e0is),
        .ep2_in_tok_i(tok), .ep2_data_rdy_i(rdy), .ep2_armed_i(armed),
        .ep1_full_i(ep1f), .ep2_empty_i(ep2e), .wr_en_i(wr), .wr_data_i(wd),
        .irq_en_i(en), .flags_o(flags), .irq_o(irq), .ep2_nak_o(nak));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick; @(posedge clk); #2; endtask

    task automatic clear_all;
        wr = 1; wd = 8'h00; tick; wr = 0; wd = 8'hFF;
    endtask

    task automatic t_reset;
        chk("R1 flags", flags, 8'h10);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 nak", {7'd0, nak}, 8'd0);
    endtask

    task automatic t_events;
        bus_rst = 1; tick; bus_rst = 0;
        chk("R3 R2 bus reset bit7", flags, 8'h90);
        setup = 1; tick; setup = 0;
        chk("R3 setup bit3", flags, 8'h98);
        e0o = 1; e0ir = 1; e0is = 1; tick; e0o = 0; e0ir = 0; e0is = 0;
        chk("R3 R2 ep0 bits2..0", flags, 8'h9F);
        tick;
        chk("R3 held", flags, 8'h9F);
    endtask

    task automatic t_clear;
        wr = 1; wd = 8'b0111_0101; tick; wr = 0; wd = 8'hFF;
        chk("R4 selective clear", flags, 8'h15);
        clear_all;
        chk("R4 clear all", flags, 8'h10);
    endtask

    task automatic t_status;
        ep1f = 1; ep2e = 0; #1;
        chk("R5 mirror live", flags, 8'h40);
        wr = 1; wd = 8'h00; tick; wr = 0; wd = 8'hFF;
        chk("R5 write no effect", flags, 8'h40);
        ep1f = 0; ep2e = 1; #1;
        chk("R5 mirror back", flags, 8'h10);
    endtask

    task automatic t_race;
        setup = 1; wr = 1; wd = 8'h00; tick; setup = 0; wr = 0; wd = 8'hFF;
        chk("R6 set wins", flags, 8'h18);
        clear_all;
    endtask

    task automatic t_irq;
        en = 8'h08; tick;
        chk("R7 masked quiet", {7'd0, irq}, 8'd0);
        setup = 1; tick; setup = 0;
        chk("R7 not yet", {7'd0, irq}, 8'd0);
        tick;
        chk("R7 raised", {7'd0, irq}, 8'd1);
        en = 8'h00; tick;
        chk("R7 masked off", {7'd0, irq}, 8'd0);
        en = 8'h10; tick;
        chk("R7 status bit irq", {7'd0, irq}, 8'd1);
        en = 8'h08; clear_all; tick;
        chk("R7 cleared", {7'd0, irq}, 8'd0);
        en = 8'h00;
    endtask

    task automatic t_nak;
        rdy = 1; tok = 1; tick; tok = 0;
        chk("R8 armed no nak", {flags[5], nak}, 8'd0);
        rdy = 0; tok = 1; tick; tok = 0;
        chk("R8 tr flag+nak", {flags[5], nak}, 8'd3);
        clear_all;
        chk("R9 nak holds after clear", {flags[5], nak}, 8'd1);
        armed = 1; tick; armed = 0;
        chk("R9 nak drops", {7'd0, nak}, 8'd0);
        tok = 1; tick; tok = 0;
        armed = 1; tick; armed = 0;
        chk("R9 drop with flag set", {flags[5], nak}, 8'd2);
        clear_all;
    endtask

    initial begin
        fork
            begin
                repeat (3) tick;
                rst_n = 1; tick;
                t_reset; t_events; t_clear; t_status; t_race; t_irq; t_nak;
            end
            begin
                repeat (5000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule